// File: doc/BRIEF.md
# Timer Interrupt Request Latch

This block sits between three timer channels and the CPU interrupt input. Each channel delivers a one-cycle terminal-count pulse. If that channel's interrupt-enable is set, the pulse sets a pending latch for the channel. The pending latches are ORed onto one shared request line.

While any latch is set, the block presents the vector of the highest-priority pending channel. Channel 0 has the highest priority and channel 2 the lowest. A one-cycle acknowledge pulse clears the latch of the channel whose vector is on the output at that moment.

A pulse that arrives while its channel is already pending does not queue a second request. It merges into the existing one, so the earlier request is lost. Each channel has a saturating counter of these merged events, brought out so a test can see them.

Top module: `tmr_irq_latch`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0 and every lost counter is 0.
- R2: A terminal pulse `tc_i[i]` with `ie_i[i]`=1 sets channel i pending. `irq_o` is high after the next rising clock edge.
- R3: A terminal pulse with `ie_i[i]`=0 is ignored. It does not set the latch and does not change the lost counter.
- R4: Clearing `ie_i[i]` while channel i is pending leaves it pending until it is acknowledged.
- R5: While any channel is pending, `vec_o` equals VEC_BASE plus the lowest pending channel index. The default VEC_BASE is 8, giving vectors 8, 9 and 10. Index 0 wins over the others.
- R6: An `ack_i` pulse clears only the latch of the channel whose vector is being presented. Other pending channels stay set, and `vec_o` moves to the next one.
- R7: An enabled pulse on a pending channel that is not being cleared in that cycle adds 1 to that channel's lost counter. One acknowledge then clears the single merged request.
- R8: An enabled pulse in the same cycle as the acknowledge that clears its own channel leaves the latch set. The lost counter is not changed.
- R9: Each lost counter saturates at 2^LOST_W-1 (15 by default). Lost counter i is `lost_o[i*LOST_W +: LOST_W]`.
- R10: `ack_i` while nothing is pending has no effect. `vec_o` stays 0 and `irq_o` stays low.
- R11: `irq_o` is high exactly when at least one channel is pending. When none is pending, `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tc_i | input | N_SRC | Terminal-count pulse per channel |
| ie_i | input | N_SRC | Interrupt enable per channel |
| ack_i | input | 1 | One-cycle acknowledge from CPU |
| irq_o | output | 1 | Shared interrupt request |
| vec_o | output | VEC_W | Vector of the highest-priority pending channel, 0 when idle |
| lost_o | output | N_SRC*LOST_W | Packed saturating merged-event counters |

## Verification
The bench targets the following corner cases:

- A pulse with its enable clear must leave both the request line and the lost counter unchanged. A design that failed to gate the pulse would raise a spurious request.
- Dropping the enable after a request is latched must not clear the request. A design that gated the stored latch instead of the incoming pulse would lose the interrupt.
- With several channels pending, each acknowledge must remove only the presented winner. A design with reversed priority, or one that cleared every latch, would show the wrong vector order.
- A pulse that coincides with its own acknowledge must leave the latch set without counting as lost. A design that let the clear win would drop a real event.
- Repeated merged events must stop at the counter's maximum. A design that wrapped the counter would read back a small number.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned TMR_N_SRC    = 3;
  localparam int unsigned TMR_VEC_W    = 8;
  localparam int unsigned TMR_VEC_BASE = 8;
  localparam int unsigned TMR_LOST_W   = 4;
endpackage

// File: rtl/tmr_irq_slot.sv
module tmr_irq_slot #(
  parameter int unsigned LOST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic [LOST_W-1:0] lost_o
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic pend_q;
  logic [LOST_W-1:0] lost_q;
  logic merge;

  // event on an already pending latch that is not being serviced now
  assign merge = hit_i & pend_q & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lost_q <= '0;
    end else begin
      pend_q <= hit_i | (pend_q & ~clr_i);
      if (merge && lost_q != LOST_MAX) lost_q <= lost_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign lost_o = lost_q;
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb #(
  parameter int unsigned N_SRC    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 8
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] clr_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             any_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] win;
  logic [N_SRC-1:0] gnt;

  // lowest index wins: scan from the top so index 0 is assigned last
  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) win = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;

  always_comb begin
    gnt = '0;
    if (any_o) gnt[win] = 1'b1;
  end

  assign clr_o = ack_i ? gnt : '0;
  assign vec_o = any_o ? VEC_W'(VEC_BASE + int'(win)) : '0;
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_SRC    = TMR_N_SRC,
  parameter int unsigned VEC_W    = TMR_VEC_W,
  parameter int unsigned VEC_BASE = TMR_VEC_BASE,
  parameter int unsigned LOST_W   = TMR_LOST_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        tc_i,
  input  logic [N_SRC-1:0]        ie_i,
  input  logic                    ack_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [N_SRC*LOST_W-1:0] lost_o
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] hit;

  // enable gates the event only, never the stored latch
  assign hit = tc_i & ie_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    tmr_irq_slot #(.LOST_W(LOST_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g]),
      .lost_o (lost_o[g*LOST_W +: LOST_W])
    );
  end

  tmr_irq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_arb (
    .pend_i (pend),
    .ack_i  (ack_i),
    .clr_o  (clr),
    .vec_o  (vec_o),
    .any_o  (irq_o)
  );
endmodule

// File: rtl/tmr_irq_latch_chk.sv
module tmr_irq_latch_chk #(
  parameter int unsigned N_SRC    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 8,
  parameter int unsigned LOST_W   = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        tc_i,
  input logic [N_SRC-1:0]        ie_i,
  input logic                    ack_i,
  input logic                    irq_o,
  input logic [VEC_W-1:0]        vec_o,
  input logic [N_SRC*LOST_W-1:0] lost_o
);
  a_r2_top_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i[0] && ie_i[0]) |=> (irq_o && vec_o == VEC_W'(VEC_BASE)));

  a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (tc_i & ie_i) == '0) |=> !irq_o);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o);

  a_r5_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + N_SRC)));

  a_r11_idle_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);

  a_r10_ack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (tc_i & ie_i) == '0 && ack_i) |=> (vec_o == '0));

  for (genvar g = 0; g < N_SRC; g++) begin : g_lost
    a_r9_lost_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lost_o[g*LOST_W +: LOST_W] >= $past(lost_o[g*LOST_W +: LOST_W]));
    a_r7_lost_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, lost_o[g*LOST_W +: LOST_W]} <= {1'b0, $past(lost_o[g*LOST_W +: LOST_W])} + 1'b1));
    a_r3_lost_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tc_i[g] && ie_i[g]) |=> $stable(lost_o[g*LOST_W +: LOST_W]));
  end
endmodule

bind tmr_irq_latch tmr_irq_latch_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .LOST_W(LOST_W)
) u_chk (.*);

// File: tb/tmr_irq_latch_test.sv
module tmr_irq_latch_test;
  localparam int N = 3;
  localparam int VW = 8;
  localparam int VB = 8;
  localparam int LW = 4;
  localparam int LMAX = (1 << LW) - 1;

  typedef struct {
    logic          irq;
    logic [VW-1:0] vec;
    logic [N*LW-1:0] lost;
    string         tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] tc_i = '0;
  logic [N-1:0] ie_i = '0;
  logic ack_i = 1'b0;
  logic irq_o;
  logic [VW-1:0] vec_o;
  logic [N*LW-1:0] lost_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t q[$];

  logic [N-1:0] m_pend = '0;
  int m_lost[N] = '{default: 0};

  always #10 clk_i = ~clk_i;

  tmr_irq_latch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tc_i(tc_i), .ie_i(ie_i),
    .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .lost_o(lost_o)
  );

  function automatic exp_t snap(string tag);
    exp_t e;
    int w;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (m_pend[i]) w = i;
    e.irq = (m_pend != '0);
    e.vec = (w < 0) ? '0 : VW'(VB + w);
    for (int i = 0; i < N; i++) e.lost[i*LW +: LW] = LW'(m_lost[i]);
    e.tag = tag;
    return e;
  endfunction

  // driver: apply one cycle of stimulus, advance the model, queue expectation
  task automatic step(input logic [N-1:0] tc, input logic [N-1:0] ie,
                      input logic ack, input string tag);
    int w;
    logic [N-1:0] nxt;
    @(negedge clk_i);
    tc_i = tc; ie_i = ie; ack_i = ack;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (m_pend[i]) w = i;
    for (int i = 0; i < N; i++) begin
      logic hit, clr;
      hit = tc[i] & ie[i];
      clr = ack && (w == i);
      if (hit && m_pend[i] && !clr && m_lost[i] < LMAX) m_lost[i]++;
      nxt[i] = hit | (m_pend[i] & ~clr);
    end
    m_pend = nxt;
    q.push_back(snap(tag));
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (irq_o !== e.irq || vec_o !== e.vec || lost_o !== e.lost) begin
          bad++;
          $display("FAIL %s: irq/vec/lost got %0b/%0d/%h expected %0b/%0d/%h",
                   e.tag, irq_o, vec_o, lost_o, e.irq, e.vec, e.lost);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 5000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles got %0d expected below 5000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (irq_o !== 1'b0 || vec_o !== '0 || lost_o !== '0) begin
      bad++;
      $display("FAIL R1: irq/vec/lost got %0b/%0d/%h expected 0/0/0", irq_o, vec_o, lost_o);
    end
    rst_ni = 1'b1;

    step(3'b111, 3'b000, 0, "R3 disabled events ignored");
    step(3'b000, 3'b111, 1, "R10 ack with nothing pending");
    step(3'b100, 3'b111, 0, "R2 timer2 latches");
    step(3'b000, 3'b000, 0, "R4 enable cleared keeps pending");
    step(3'b100, 3'b011, 0, "R3 disabled event on pending does not count");
    step(3'b010, 3'b111, 0, "R5 timer1 outranks timer2");
    step(3'b001, 3'b111, 0, "R5 timer0 highest");
    step(3'b000, 3'b111, 1, "R6 ack clears timer0 only");
    step(3'b000, 3'b111, 1, "R6 ack clears timer1 only");
    step(3'b000, 3'b111, 1, "R11 last ack idles line");
    step(3'b000, 3'b111, 1, "R10 ack idle again");
    step(3'b001, 3'b111, 0, "R2 timer0 latches");
    step(3'b001, 3'b111, 0, "R7 merged event counted");
    step(3'b000, 3'b111, 1, "R7 one ack clears merged request");
    step(3'b001, 3'b111, 0, "R8 set before coincident ack");
    step(3'b001, 3'b111, 1, "R8 event with own ack stays set");
    step(3'b000, 3'b111, 1, "R8 clears after");
    step(3'b001, 3'b111, 0, "R6 setup timer0");
    step(3'b010, 3'b111, 1, "R8 other channel event during ack not lost");
    step(3'b000, 3'b111, 1, "R6 drain timer1");
    for (int k = 0; k < 20; k++) step(3'b010, 3'b010, 0, "R9 lost counter saturates");
    step(3'b000, 3'b000, 1, "R9 drain");
    step(3'b000, 3'b000, 0, "R11 idle");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule